// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a fully associative translation cache holding recent virtual-to-physical page mappings. Each slot keeps a virtual page tag, a physical page number, an address-space identifier, a global flag, one read-enable and one write-enable bit per privilege mode, a fault-on-read flag, a fault-on-write flag and a valid flag. A combinational lookup port compares a virtual page and the current address-space identifier against every slot at once. On a hit it returns the winning slot index and that slot's contents.

Software or a page walker fills the cache through the insert port. The slot written is the one named by a round-robin replacement pointer. Three invalidation commands are available. The first clears the whole cache. The second removes every non-global mapping. The third removes the mappings of one virtual page that are visible to one address space.

At most one command acts per clock. The block leaves translation, permission checking and fault reporting to the logic around it.

Top module: `asn_tlb`

## Requirements
- R1: A lookup hits only when a slot is valid, its tag equals `lk_vpn`, and either its global flag is 1 or its stored identifier equals `lk_asn`.
- R2: On a hit, `lk_idx` and the `lk_*` data outputs give the matching slot's index and stored fields in the same cycle. On a miss, `lk_hit` is 0 and `lk_idx` and all data outputs are 0.
- R3: An insert writes the slot named by the replacement pointer, overwriting any valid mapping held there, and sets that slot valid. The new mapping is visible to lookups from the next cycle.
- R4: The replacement pointer starts at 0. It moves up by one after every insert and returns to 0 after slot ENTRIES-1.
- R5: `inv_all` invalidates every slot and returns the replacement pointer to 0.
- R6: `inv_proc` invalidates every slot whose global flag is 0. Global slots and the replacement pointer are unchanged.
- R7: `inv_va` invalidates every valid slot whose tag equals `inv_vpn` and that is either global or holds identifier `inv_asn`. All other slots are unchanged.
- R8: When several commands are asserted in one cycle, only the highest-priority one acts. The order, highest first, is `inv_all`, `inv_proc`, `inv_va`, `ins_en`. The others are ignored.
- R9: After reset no lookup hits, and the first insert lands in slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vpn | input | VPN_W | Virtual page to look up |
| lk_asn | input | ASN_W | Current address-space identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Index of the hitting slot |
| lk_ppn | output | PPN_W | Physical page of the hitting slot |
| lk_global | output | 1 | Global flag of the hitting slot |
| lk_rd_mask | output | MODES | Per-mode read enables |
| lk_wr_mask | output | MODES | Per-mode write enables |
| lk_fault_rd | output | 1 | Fault-on-read flag |
| lk_fault_wr | output | 1 | Fault-on-write flag |
| ins_en | input | 1 | Insert command |
| ins_vpn | input | VPN_W | Tag for the new mapping |
| ins_ppn | input | PPN_W | Physical page for the new mapping |
| ins_asn | input | ASN_W | Identifier for the new mapping |
| ins_global | input | 1 | Global flag for the new mapping |
| ins_rd_mask | input | MODES | Read enables for the new mapping |
| ins_wr_mask | input | MODES | Write enables for the new mapping |
| ins_fault_rd | input | 1 | Fault-on-read flag for the new mapping |
| ins_fault_wr | input | 1 | Fault-on-write flag for the new mapping |
| inv_all | input | 1 | Invalidate every slot |
| inv_proc | input | 1 | Invalidate all non-global slots |
| inv_va | input | 1 | Invalidate by page and identifier |
| inv_vpn | input | VPN_W | Page for `inv_va` |
| inv_asn | input | ASN_W | Identifier for `inv_va` |

## Verification
The hardest case to reach is a by-page invalidation that must tell apart slots sharing one tag. One such slot belongs to the named address space and must go. Another belongs to a different address space and must stay. A third is global and must go whatever identifier is given. The stimulus builds this by inserting the same page under two identifiers, plus a separate global page, in known slots. It then issues invalidations with matching and non-matching identifiers and looks up each slot afterwards under its own identifier. Wrap-around of the replacement pointer is reached by filling every slot and inserting twice more.

// File: rtl/asn_tlb_pkg.sv
package asn_tlb_pkg;

  // One command is carried out per cycle; decoded by priority.
  typedef enum logic [2:0] {
    OP_IDLE       = 3'd0,
    OP_INSERT     = 3'd1,
    OP_FLUSH_VA   = 3'd2,
    OP_FLUSH_PROC = 3'd3,
    OP_FLUSH_ALL  = 3'd4
  } tlb_op_e;

endpackage

// File: rtl/asn_tlb_cmd.sv
module asn_tlb_cmd
  import asn_tlb_pkg::*;
(
  input  logic    ins_en,
  input  logic    inv_all,
  input  logic    inv_proc,
  input  logic    inv_va,
  output tlb_op_e op
);

  // Priority: full flush, process flush, address flush, insert (R8)
  always_comb begin
    if (inv_all)       op = OP_FLUSH_ALL;
    else if (inv_proc) op = OP_FLUSH_PROC;
    else if (inv_va)   op = OP_FLUSH_VA;
    else if (ins_en)   op = OP_INSERT;
    else               op = OP_IDLE;
  end

endmodule

// File: rtl/asn_tlb_cam.sv
module asn_tlb_cam #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 30,
  parameter int ASN_W   = 8
) (
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0]            glob,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tag,
  input  logic [ENTRIES-1:0][ASN_W-1:0] asn,
  input  logic [VPN_W-1:0]              lk_vpn,
  input  logic [ASN_W-1:0]              lk_asn,
  input  logic [VPN_W-1:0]              fa_vpn,
  input  logic [ASN_W-1:0]              fa_asn,
  output logic [ENTRIES-1:0]            lk_match,
  output logic [ENTRIES-1:0]            fa_match
);

  // One comparator pair per slot for lookup and one for address flush
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_comb begin
      lk_match[g] = valid[g] && (tag[g] == lk_vpn) && (glob[g] || (asn[g] == lk_asn));
      fa_match[g] = valid[g] && (tag[g] == fa_vpn) && (glob[g] || (asn[g] == fa_asn));
    end
  end

endmodule

// File: rtl/asn_tlb_prio.sv
module asn_tlb_prio #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);

  // Lowest set index wins
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (any) assert (req[idx]) else $error("p_grant_is_request_r2");
    if (!any) assert (req == '0) else $error("p_no_grant_when_idle_r2");
  end

endmodule

// File: rtl/asn_tlb_victim.sv
module asn_tlb_victim #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  output logic [IDX_W-1:0] ptr
);

  logic [IDX_W-1:0] ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_en = adv || clr;
    if (clr)               ptr_d = '0;
    else if (ptr == LAST)  ptr_d = '0;
    else                   ptr_d = ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (ptr_en) ptr <= ptr_d;
  end

  p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);

  p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && ptr == LAST) |=> (ptr == '0));

  p_ptr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ptr == '0));

  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(ptr));

endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
  import asn_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 30,
  parameter int PPN_W   = 28,
  parameter int ASN_W   = 8,
  parameter int MODES   = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [ASN_W-1:0] lk_asn,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_global,
  output logic [MODES-1:0] lk_rd_mask,
  output logic [MODES-1:0] lk_wr_mask,
  output logic             lk_fault_rd,
  output logic             lk_fault_wr,
  input  logic             ins_en,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic [ASN_W-1:0] ins_asn,
  input  logic             ins_global,
  input  logic [MODES-1:0] ins_rd_mask,
  input  logic [MODES-1:0] ins_wr_mask,
  input  logic             ins_fault_rd,
  input  logic             ins_fault_wr,
  input  logic             inv_all,
  input  logic             inv_proc,
  input  logic             inv_va,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic [ASN_W-1:0] inv_asn
);

  // Slot storage; only valid_q is reset, data is qualified by it
  logic [ENTRIES-1:0]            valid_q, valid_d;
  logic [ENTRIES-1:0]            glob_q;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  logic [ENTRIES-1:0][ASN_W-1:0] asn_q;
  logic [ENTRIES-1:0][MODES-1:0] rdm_q;
  logic [ENTRIES-1:0][MODES-1:0] wrm_q;
  logic [ENTRIES-1:0]            fr_q;
  logic [ENTRIES-1:0]            fw_q;

  tlb_op_e            op;
  logic [IDX_W-1:0]   vic_ptr;
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] fa_match;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [ENTRIES-1:0] wr_sel;

  asn_tlb_cmd u_cmd (
    .ins_en   (ins_en),
    .inv_all  (inv_all),
    .inv_proc (inv_proc),
    .inv_va   (inv_va),
    .op       (op)
  );

  asn_tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (op == OP_INSERT),
    .clr   (op == OP_FLUSH_ALL),
    .ptr   (vic_ptr)
  );

  asn_tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_cam (
    .valid    (valid_q),
    .glob     (glob_q),
    .tag      (tag_q),
    .asn      (asn_q),
    .lk_vpn   (lk_vpn),
    .lk_asn   (lk_asn),
    .fa_vpn   (inv_vpn),
    .fa_asn   (inv_asn),
    .lk_match (lk_match),
    .fa_match (fa_match)
  );

  asn_tlb_prio #(.ENTRIES(ENTRIES)) u_prio (
    .req (lk_match),
    .any (hit),
    .idx (hit_idx)
  );

  // Next-state of valid flags and per-slot write enables
  always_comb begin
    wr_sel = '0;
    if (op == OP_INSERT) wr_sel[vic_ptr] = 1'b1;
    unique case (op)
      OP_FLUSH_ALL:  valid_d = '0;
      OP_FLUSH_PROC: valid_d = valid_q & glob_q;
      OP_FLUSH_VA:   valid_d = valid_q & ~fa_match;
      OP_INSERT:     valid_d = valid_q | wr_sel;
      default:       valid_d = valid_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_data
    always_ff @(posedge clk) begin
      if (wr_sel[g]) begin
        tag_q[g]  <= ins_vpn;
        ppn_q[g]  <= ins_ppn;
        asn_q[g]  <= ins_asn;
        glob_q[g] <= ins_global;
        rdm_q[g]  <= ins_rd_mask;
        wrm_q[g]  <= ins_wr_mask;
        fr_q[g]   <= ins_fault_rd;
        fw_q[g]   <= ins_fault_wr;
      end
    end
  end

  // Read-out: zero on miss
  always_comb begin
    lk_hit      = hit;
    lk_idx      = hit_idx;
    lk_ppn      = hit ? ppn_q[hit_idx]  : '0;
    lk_global   = hit ? glob_q[hit_idx] : 1'b0;
    lk_rd_mask  = hit ? rdm_q[hit_idx]  : '0;
    lk_wr_mask  = hit ? wrm_q[hit_idx]  : '0;
    lk_fault_rd = hit ? fr_q[hit_idx]   : 1'b0;
    lk_fault_wr = hit ? fw_q[hit_idx]   : 1'b0;
  end

  p_hit_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (valid_q[lk_idx] && tag_q[lk_idx] == lk_vpn
                && (glob_q[lk_idx] || asn_q[lk_idx] == lk_asn)));

  p_insert_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_INSERT) |=> (valid_q[$past(vic_ptr)] && tag_q[$past(vic_ptr)] == $past(ins_vpn)));

  p_flush_all_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_q == '0));

  p_proc_keeps_global_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_FLUSH_PROC) |=> ((valid_q & ~glob_q) == '0) && (valid_q == ($past(valid_q) & glob_q)));

  p_va_flush_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_FLUSH_VA) |=> ((valid_q & ~$past(valid_q)) == '0));

  p_lower_cmd_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && (inv_all || inv_proc || inv_va)) |=> ((valid_q & ~$past(valid_q)) == '0));

endmodule

// File: tb/asn_tlb_tb_top.sv
module asn_tlb_tb_top;

  localparam int CLK_P   = 10;
  localparam int ENTRIES = 8;
  localparam int VPN_W   = 30;
  localparam int PPN_W   = 28;
  localparam int ASN_W   = 8;
  localparam int MODES   = 4;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic [ASN_W-1:0] lk_asn = '0;
  logic             lk_hit;
  logic [IDX_W-1:0] lk_idx;
  logic [PPN_W-1:0] lk_ppn;
  logic             lk_global;
  logic [MODES-1:0] lk_rd_mask;
  logic [MODES-1:0] lk_wr_mask;
  logic             lk_fault_rd;
  logic             lk_fault_wr;
  logic             ins_en = 1'b0;
  logic [VPN_W-1:0] ins_vpn = '0;
  logic [PPN_W-1:0] ins_ppn = '0;
  logic [ASN_W-1:0] ins_asn = '0;
  logic             ins_global = 1'b0;
  logic [MODES-1:0] ins_rd_mask = '0;
  logic [MODES-1:0] ins_wr_mask = '0;
  logic             ins_fault_rd = 1'b0;
  logic             ins_fault_wr = 1'b0;
  logic             inv_all = 1'b0;
  logic             inv_proc = 1'b0;
  logic             inv_va = 1'b0;
  logic [VPN_W-1:0] inv_vpn = '0;
  logic [ASN_W-1:0] inv_asn = '0;

  int tests = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  asn_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W), .MODES(MODES)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .lk_ppn(lk_ppn), .lk_global(lk_global), .lk_rd_mask(lk_rd_mask),
    .lk_wr_mask(lk_wr_mask), .lk_fault_rd(lk_fault_rd), .lk_fault_wr(lk_fault_wr),
    .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn), .ins_asn(ins_asn),
    .ins_global(ins_global), .ins_rd_mask(ins_rd_mask), .ins_wr_mask(ins_wr_mask),
    .ins_fault_rd(ins_fault_rd), .ins_fault_wr(ins_fault_wr),
    .inv_all(inv_all), .inv_proc(inv_proc), .inv_va(inv_va),
    .inv_vpn(inv_vpn), .inv_asn(inv_asn)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle of commands starting at a falling edge
  task automatic issue(input logic ins, input logic all, input logic proc, input logic va,
                       input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                       input logic [ASN_W-1:0] asn, input logic glob,
                       input logic [MODES-1:0] rd, input logic [MODES-1:0] wr,
                       input logic fr, input logic fw);
    @(negedge clk);
    ins_en = ins; inv_all = all; inv_proc = proc; inv_va = va;
    ins_vpn = vpn; ins_ppn = ppn; ins_asn = asn; ins_global = glob;
    ins_rd_mask = rd; ins_wr_mask = wr; ins_fault_rd = fr; ins_fault_wr = fw;
    inv_vpn = vpn; inv_asn = asn;
    @(negedge clk);
    ins_en = 1'b0; inv_all = 1'b0; inv_proc = 1'b0; inv_va = 1'b0;
  endtask

  task automatic ins(input logic [VPN_W-1:0] vpn, input logic [ASN_W-1:0] asn, input logic glob);
    issue(1'b1, 1'b0, 1'b0, 1'b0, vpn, PPN_W'(vpn) ^ 28'h5A5, asn, glob, 4'h0, 4'h0, 1'b0, 1'b0);
  endtask

  task automatic flush_all();
    issue(1'b0, 1'b1, 1'b0, 1'b0, '0, '0, '0, 1'b0, '0, '0, 1'b0, 1'b0);
  endtask

  task automatic look(input logic [VPN_W-1:0] vpn, input logic [ASN_W-1:0] asn);
    lk_vpn = vpn; lk_asn = asn;
    #1;
  endtask

  task automatic t_reset();
    look(30'h0, 8'h0);
    chk("R9 no hit after reset", lk_hit, 0);
    ins(30'h77, 8'h1, 1'b0);
    look(30'h77, 8'h1);
    chk("R9 first insert slot 0", lk_idx, 0);
  endtask

  task automatic t_fields();
    flush_all();
    issue(1'b1, 1'b0, 1'b0, 1'b0, 30'h1234, 28'hABCDE, 8'h3, 1'b0, 4'b0011, 4'b0001, 1'b1, 1'b0);
    issue(1'b1, 1'b0, 1'b0, 1'b0, 30'h2000, 28'h00777, 8'h5, 1'b1, 4'b1111, 4'b0110, 1'b0, 1'b1);
    look(30'h1234, 8'h3);
    chk("R2 hit", lk_hit, 1);
    chk("R2 idx", lk_idx, 0);
    chk("R2 ppn", lk_ppn, 28'hABCDE);
    chk("R2 rd mask", lk_rd_mask, 4'b0011);
    chk("R2 wr mask", lk_wr_mask, 4'b0001);
    chk("R2 fault flags", {lk_fault_rd, lk_fault_wr, lk_global}, 3'b100);
    look(30'h1234, 8'h4);
    chk("R1 asn mismatch misses", lk_hit, 0);
    chk("R2 miss zero ppn", lk_ppn, 0);
    look(30'h1235, 8'h3);
    chk("R1 tag mismatch misses", lk_hit, 0);
    look(30'h2000, 8'h99);
    chk("R1 global hits any asn", {lk_hit, lk_idx}, {1'b1, 3'd1});
    chk("R2 global fields", {lk_global, lk_fault_wr, lk_wr_mask}, {1'b1, 1'b1, 4'b0110});
  endtask

  task automatic t_wrap();
    flush_all();
    for (int i = 0; i < ENTRIES; i++) ins(30'h100 + 30'(i), 8'h1, 1'b0);
    for (int i = 0; i < ENTRIES; i++) begin
      look(30'h100 + 30'(i), 8'h1);
      chk("R4 sequential slots", {lk_hit, lk_idx}, {1'b1, 3'(i)});
    end
    ins(30'h200, 8'h1, 1'b0);
    look(30'h200, 8'h1);
    chk("R4 wrap to slot 0", {lk_hit, lk_idx}, {1'b1, 3'd0});
    look(30'h100, 8'h1);
    chk("R3 overwritten mapping gone", lk_hit, 0);
    ins(30'h201, 8'h1, 1'b0);
    look(30'h201, 8'h1);
    chk("R4 next after wrap", lk_idx, 1);
    look(30'h101, 8'h1);
    chk("R3 slot 1 overwritten", lk_hit, 0);
  endtask

  task automatic t_proc();
    flush_all();
    ins(30'h310, 8'h2, 1'b0);
    ins(30'h320, 8'h2, 1'b1);
    ins(30'h330, 8'h7, 1'b0);
    issue(1'b0, 1'b0, 1'b1, 1'b0, '0, '0, '0, 1'b0, '0, '0, 1'b0, 1'b0);
    look(30'h310, 8'h2);
    chk("R6 non-global removed", lk_hit, 0);
    look(30'h330, 8'h7);
    chk("R6 non-global removed b", lk_hit, 0);
    look(30'h320, 8'h2);
    chk("R6 global kept", {lk_hit, lk_idx}, {1'b1, 3'd1});
    ins(30'h340, 8'h2, 1'b0);
    look(30'h340, 8'h2);
    chk("R6 pointer unchanged", lk_idx, 3);
  endtask

  task automatic t_addr();
    flush_all();
    ins(30'h400, 8'h2, 1'b0);
    ins(30'h500, 8'h2, 1'b0);
    ins(30'h400, 8'h3, 1'b0);
    ins(30'h600, 8'h4, 1'b1);
    issue(1'b0, 1'b0, 1'b0, 1'b1, 30'h400, '0, 8'h2, 1'b0, '0, '0, 1'b0, 1'b0);
    look(30'h400, 8'h2);
    chk("R7 matching asn removed", lk_hit, 0);
    look(30'h400, 8'h3);
    chk("R7 other asn same tag kept", {lk_hit, lk_idx}, {1'b1, 3'd2});
    look(30'h500, 8'h2);
    chk("R7 other tag kept", {lk_hit, lk_idx}, {1'b1, 3'd1});
    issue(1'b0, 1'b0, 1'b0, 1'b1, 30'h500, '0, 8'h9, 1'b0, '0, '0, 1'b0, 1'b0);
    look(30'h500, 8'h2);
    chk("R7 asn mismatch not removed", lk_hit, 1);
    issue(1'b0, 1'b0, 1'b0, 1'b1, 30'h600, '0, 8'h9, 1'b0, '0, '0, 1'b0, 1'b0);
    look(30'h600, 8'h4);
    chk("R7 global removed any asn", lk_hit, 0);
  endtask

  task automatic t_all();
    ins(30'h700, 8'h1, 1'b1);
    flush_all();
    look(30'h700, 8'h1);
    chk("R5 global removed", lk_hit, 0);
    look(30'h400, 8'h3);
    chk("R5 all removed", lk_hit, 0);
    ins(30'h710, 8'h1, 1'b0);
    look(30'h710, 8'h1);
    chk("R5 pointer reset", {lk_hit, lk_idx}, {1'b1, 3'd0});
  endtask

  task automatic t_prio();
    flush_all();
    ins(30'h800, 8'h1, 1'b0);
    ins(30'h810, 8'h1, 1'b1);
    // address flush of 0x800 together with an insert of the same page
    issue(1'b1, 1'b0, 1'b0, 1'b1, 30'h800, 28'h1, 8'h1, 1'b0, '0, '0, 1'b0, 1'b0);
    look(30'h800, 8'h1);
    chk("R8 flush beats insert", lk_hit, 0);
    ins(30'h820, 8'h1, 1'b0);
    look(30'h820, 8'h1);
    chk("R8 ignored insert kept pointer", lk_idx, 2);
    // process flush and address flush of a global page together
    issue(1'b0, 1'b0, 1'b1, 1'b1, 30'h810, '0, 8'h1, 1'b0, '0, '0, 1'b0, 1'b0);
    look(30'h810, 8'h1);
    chk("R8 proc beats addr flush", lk_hit, 1);
    look(30'h820, 8'h1);
    chk("R8 proc flush acted", lk_hit, 0);
    issue(1'b1, 1'b1, 1'b0, 1'b0, 30'h830, '0, 8'h1, 1'b0, '0, '0, 1'b0, 1'b0);
    look(30'h830, 8'h1);
    chk("R8 full flush beats insert", lk_hit, 0);
    look(30'h810, 8'h1);
    chk("R8 full flush acted", lk_hit, 0);
  endtask

  initial begin
    #(CLK_P * 20000);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fields();
    t_wrap();
    t_proc();
    t_addr();
    t_all();
    t_prio();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule